// File: doc/BRIEF.md
# Parallel Sorted-Set Membership Probe

The block answers whether a 64-bit key belongs to a fixed, ascending list of unique values, and if so at which list position. The list is spread across `NBANK` small memories with synchronous reads. A host writes the list, already sorted and interleaved, one word at a time through a write port that takes a bank number, an address and a data word. A pulse on `load_done_i` then enables lookups. Keys enter through a valid/ready handshake. Results leave through a second valid/ready handshake as a hit flag and an index.

A list position p is written as p = N·(NBANK−1)+M. N picks one of `NBANK` bins, and M picks one of `NBANK−1` slots inside that bin. Bank m at address n holds element n·(NBANK−1)+m, for m from 0 to NBANK−2. The last bank holds no bin data. Each bank has depth 2·NBANK. Address NBANK of bank n holds the head of bin n, which is element n·(NBANK−1).

A lookup has two phases. In the first, all heads are read in one cycle, and relational compares pick the bin with head(N) ≤ key < head(N+1). In the second, address N is read in every bank at once and each word is compared with the key for equality. Bins and slots whose position is at or beyond `LIST_LEN` are masked out. The host pads those positions with all-ones.

Top module: `sorted_set_probe`

## Requirements
- R1: After reset, `key_ready_o` and `res_valid_o` are 0, and no key is accepted until a `load_done_i` pulse has been seen.
- R2: While `load_we_i` is 1, `key_ready_o` is 0. A write clears the loaded state, and a later `load_done_i` pulse sets `key_ready_o` again while the block is idle.
- R3: The first phase picks the highest valid bin N with head(N) ≤ key, where a bin is valid when N·(NBANK−1) < LIST_LEN.
- R4: When the key equals element p with p < LIST_LEN, the result has `res_hit_o`=1 and `res_idx_o`=p.
- R5: When the key is absent from the list, the result has `res_hit_o`=0 and `res_idx_o`=0.
- R6: A key below head(0) is a miss, and `res_valid_o` rises on the first rising edge after the accepting edge.
- R7: For every other key, `res_valid_o` rises on the second rising edge after the accepting edge, and is 0 on the first.
- R8: Only one lookup is in flight. `key_ready_o` is 0 from the accepting edge until the edge after the result is taken with `res_ready_i`=1, and `key_ready_o` and `res_valid_o` are never 1 together.
- R9: While `res_valid_o`=1 and `res_ready_i`=0, the result holds with `res_hit_o` and `res_idx_o` stable.
- R10: A hit is never reported at an index ≥ LIST_LEN, so an all-ones key that matches only padding is a miss.
- R11: The last valid bin has no upper bound. A key above every element is searched there and misses, and the last element hits with index LIST_LEN−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_we_i | input | 1 | Host write strobe |
| load_bank_i | input | $clog2(NBANK) | Bank to write |
| load_addr_i | input | $clog2(NBANK)+1 | Word address inside the bank |
| load_data_i | input | KW | Word to write |
| load_done_i | input | 1 | Pulse marking that the list is complete |
| key_valid_i | input | 1 | Key offered |
| key_i | input | KW | Key to look up |
| key_ready_o | output | 1 | Key can be accepted |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result taken |
| res_hit_o | output | 1 | Key found |
| res_idx_o | output | $clog2(NBANK*(NBANK-1)) | List index of the hit, 0 on a miss |

## Verification
The bench builds the block with NBANK=8 and LIST_LEN=40, which gives capacity 56. Under that configuration, bins 6 and 7 are entirely padding, and slots 5 and 6 of bin 5 are padding as well. This puts the masking of padded bins and padded slots within reach of short directed keys, including an all-ones key. The small bin size also brings bin heads, last slots of a bin, the last valid bin and keys below the first head within reach in a few lookups.

// File: rtl/sset_pkg.sv
package sset_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HEAD, ST_BIN, ST_DONE} st_e;
endpackage

// File: rtl/sset_bank.sv
module sset_bank #(
  parameter int DW = 64,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/sset_bin_sel.sv
module sset_bin_sel #(
  parameter int NBANK    = 16,
  parameter int DW       = 64,
  parameter int LIST_LEN = 240,
  parameter int BW       = 4
) (
  input  logic [NBANK*DW-1:0] heads_i,
  input  logic [DW-1:0]       key_i,
  output logic                found_o,
  output logic [BW-1:0]       bin_o
);
  // Sorted heads give a thermometer of ge bits; take the highest.
  always_comb begin
    found_o = 1'b0;
    bin_o   = '0;
    for (int n = 0; n < NBANK; n++) begin
      if ((n * (NBANK - 1) < LIST_LEN) && (key_i >= heads_i[n*DW +: DW])) begin
        found_o = 1'b1;
        bin_o   = BW'(n);
      end
    end
  end
endmodule

// File: rtl/sset_match.sv
module sset_match #(
  parameter int NBANK    = 16,
  parameter int DW       = 64,
  parameter int LIST_LEN = 240,
  parameter int BW       = 4,
  parameter int IW       = 8
) (
  input  logic [NBANK*DW-1:0] words_i,
  input  logic [DW-1:0]       key_i,
  input  logic [BW-1:0]       bin_i,
  output logic                hit_o,
  output logic [IW-1:0]       idx_o
);
  logic [NBANK-2:0] eq;

  always_comb begin
    for (int m = 0; m < NBANK - 1; m++) begin
      eq[m] = (int'(bin_i) * (NBANK - 1) + m < LIST_LEN) &&
              (words_i[m*DW +: DW] == key_i);
    end
  end

  // Unique sorted list: at most one eq bit; lowest wins regardless.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int m = NBANK - 2; m >= 0; m--) begin
      if (eq[m]) begin
        hit_o = 1'b1;
        idx_o = IW'(int'(bin_i) * (NBANK - 1) + m);
      end
    end
  end
endmodule

// File: rtl/sorted_set_probe.sv
module sorted_set_probe
  import sset_pkg::*;
#(
  parameter int NBANK    = 16,
  parameter int KW       = 64,
  parameter int LIST_LEN = NBANK * (NBANK - 1),
  localparam int BW      = $clog2(NBANK),
  localparam int AW      = BW + 1,
  localparam int IW      = $clog2(NBANK * (NBANK - 1))
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_we_i,
  input  logic [BW-1:0] load_bank_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [KW-1:0] load_data_i,
  input  logic          load_done_i,
  input  logic          key_valid_i,
  input  logic [KW-1:0] key_i,
  output logic          key_ready_o,
  output logic          res_valid_o,
  input  logic          res_ready_i,
  output logic          res_hit_o,
  output logic [IW-1:0] res_idx_o
);
  localparam logic [AW-1:0] HEAD_ADDR = AW'(NBANK);

  st_e               st_q;
  logic              loaded_q;
  logic [KW-1:0]     key_q;
  logic [BW-1:0]     bin_q;
  logic              hit_q;
  logic [IW-1:0]     idx_q;
  logic [AW-1:0]     rd_addr;
  logic [NBANK*KW-1:0] rdata;
  logic              bin_found;
  logic [BW-1:0]     bin_sel;
  logic              m_hit;
  logic [IW-1:0]     m_idx;

  assign rd_addr = (st_q == ST_HEAD) ? AW'(bin_sel) : HEAD_ADDR;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sset_bank #(.DW(KW), .AW(AW)) u_bank (
      .clk_i   (clk_i),
      .we_i    (load_we_i && (load_bank_i == BW'(g))),
      .waddr_i (load_addr_i),
      .wdata_i (load_data_i),
      .raddr_i (rd_addr),
      .rdata_o (rdata[g*KW +: KW])
    );
  end

  sset_bin_sel #(.NBANK(NBANK), .DW(KW), .LIST_LEN(LIST_LEN), .BW(BW)) u_bin_sel (
    .heads_i (rdata),
    .key_i   (key_q),
    .found_o (bin_found),
    .bin_o   (bin_sel)
  );

  sset_match #(.NBANK(NBANK), .DW(KW), .LIST_LEN(LIST_LEN), .BW(BW), .IW(IW)) u_match (
    .words_i (rdata),
    .key_i   (key_q),
    .bin_i   (bin_q),
    .hit_o   (m_hit),
    .idx_o   (m_idx)
  );

  assign key_ready_o = (st_q == ST_IDLE) && loaded_q && !load_we_i;
  assign res_valid_o = (st_q == ST_DONE);
  assign res_hit_o   = hit_q;
  assign res_idx_o   = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
    end else if (load_we_i) begin
      loaded_q <= 1'b0;
    end else if (load_done_i) begin
      loaded_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      key_q <= '0;
      bin_q <= '0;
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (key_valid_i && key_ready_o) begin
          key_q <= key_i;
          st_q  <= ST_HEAD;
        end
        ST_HEAD: if (bin_found) begin
          bin_q <= bin_sel;
          st_q  <= ST_BIN;
        end else begin
          hit_q <= 1'b0;
          idx_q <= '0;
          st_q  <= ST_DONE;
        end
        ST_BIN: begin
          hit_q <= m_hit;
          idx_q <= m_hit ? m_idx : '0;
          st_q  <= ST_DONE;
        end
        ST_DONE: if (res_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sset_chk.sv
module sset_chk #(
  parameter int NBANK    = 16,
  parameter int LIST_LEN = 240,
  parameter int IW       = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_we_i,
  input logic          key_valid_i,
  input logic          key_ready_o,
  input logic          res_valid_o,
  input logic          res_ready_i,
  input logic          res_hit_o,
  input logic [IW-1:0] res_idx_o
);
  // R8
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && key_ready_o) |=> !key_ready_o);
  // R8
  ready_valid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(key_ready_o && res_valid_o));
  // R9
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_hit_o) && $stable(res_idx_o)));
  // R7
  no_early_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && key_ready_o) |=> !res_valid_o);
  // R10
  hit_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_hit_o) |-> (int'(res_idx_o) < LIST_LEN));
  // R5
  miss_idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_idx_o == '0));
  // R2
  load_blocks_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |-> !key_ready_o);
endmodule

bind sorted_set_probe sset_chk #(.NBANK(NBANK), .LIST_LEN(LIST_LEN), .IW(IW)) u_sset_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_we_i   (load_we_i),
  .key_valid_i (key_valid_i),
  .key_ready_o (key_ready_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_hit_o   (res_hit_o),
  .res_idx_o   (res_idx_o)
);

// File: tb/tb_sorted_set_probe.sv
`timescale 1ns/1ps
module tb_sorted_set_probe;
  localparam int NB  = 8;
  localparam int L   = 40;
  localparam int KW  = 64;
  localparam int BW  = $clog2(NB);
  localparam int AW  = BW + 1;
  localparam int IW  = $clog2(NB * (NB - 1));
  localparam logic [KW-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_we = 1'b0;
  logic [BW-1:0] load_bank = '0;
  logic [AW-1:0] load_addr = '0;
  logic [KW-1:0] load_data = '0;
  logic          load_done = 1'b0;
  logic          key_valid = 1'b0;
  logic [KW-1:0] key = '0;
  logic          key_ready;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic          res_hit;
  logic [IW-1:0] res_idx;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sorted_set_probe #(.NBANK(NB), .KW(KW), .LIST_LEN(L)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .load_we_i(load_we), .load_bank_i(load_bank), .load_addr_i(load_addr),
    .load_data_i(load_data), .load_done_i(load_done),
    .key_valid_i(key_valid), .key_i(key), .key_ready_o(key_ready),
    .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_hit_o(res_hit), .res_idx_o(res_idx)
  );

  function automatic logic [KW-1:0] lv(int i);
    return 64'h0123_4567_0000_0000 + 64'(i) * 64'd1000 + 64'd500;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void ref_find(logic [KW-1:0] k, output logic h, output int ix);
    h = 1'b0; ix = 0;
    for (int i = 0; i < L; i++) if (lv(i) == k) begin h = 1'b1; ix = i; end
  endfunction

  // Cycle-by-cycle reference model
  logic m_loaded = 0, m_busy = 0, m_valid = 0, m_hit = 0, p_hit = 0;
  int   m_cnt = 0, m_idx = 0, p_idx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_loaded = 0; m_busy = 0; m_valid = 0; m_hit = 0; m_idx = 0; m_cnt = 0;
    end else begin
      logic rdy;
      rdy = m_loaded && !load_we && !m_busy && !m_valid;
      if (load_we) m_loaded = 0;
      else if (load_done) m_loaded = 1;
      if (m_valid && res_ready) m_valid = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_valid = 1; m_hit = p_hit; m_idx = p_idx;
        end
      end
      if (key_valid && rdy) begin
        m_busy = 1;
        m_cnt = (key < lv(0)) ? 1 : 2;
        ref_find(key, p_hit, p_idx);
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk("R8 ready", 64'(key_ready), 64'(m_loaded && !load_we && !m_busy && !m_valid));
      chk("R7 valid", 64'(res_valid), 64'(m_valid));
      if (res_valid && m_valid) begin
        chk("R4 hit", 64'(res_hit), 64'(m_hit));
        chk("R4 idx", 64'(res_idx), 64'(m_idx));
      end
    end
  end

  task automatic load_all();
    for (int b = 0; b < NB; b++) begin
      for (int a = 0; a <= NB; a++) begin
        @(negedge clk);
        load_we = 1'b1; load_bank = BW'(b); load_addr = AW'(a);
        if (a < NB) load_data = (b < NB - 1 && a * (NB - 1) + b < L) ? lv(a * (NB - 1) + b) : ONES;
        else        load_data = (b * (NB - 1) < L) ? lv(b * (NB - 1)) : ONES;
        if (b == 3 && a == 2) begin
          key_valid = 1'b1; key = lv(0);
          #1 chk("R2 no ready while loading", 64'(key_ready), 64'd0);
        end
      end
    end
    @(negedge clk);
    load_we = 1'b0; key_valid = 1'b0;
    #1 chk("R2 not ready before done", 64'(key_ready), 64'd0);
    @(negedge clk); load_done = 1'b1;
    @(negedge clk); load_done = 1'b0;
    chk("R2 ready after done", 64'(key_ready), 64'd1);
  endtask

  task automatic lookup(logic [KW-1:0] k, string tag, int hold);
    logic eh; int ei; int lat;
    ref_find(k, eh, ei);
    while (!key_ready) @(negedge clk);
    key_valid = 1'b1; key = k;
    @(posedge clk);
    @(negedge clk); key_valid = 1'b0;
    lat = 0;
    do begin @(posedge clk); lat++; #5; end while (!res_valid && lat < 10);
    chk({tag, " latency"}, 64'(lat), (k < lv(0)) ? 64'd1 : 64'd2);
    chk({tag, " hit"}, 64'(res_hit), 64'(eh));
    chk({tag, " idx"}, 64'(res_idx), 64'(ei));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R9 held valid", 64'(res_valid), 64'd1);
      chk("R9 held idx", 64'(res_idx), 64'(ei));
    end
    @(negedge clk); res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
    chk("R8 ready after take", 64'(key_ready), 64'd1);
  endtask

  initial begin
    #(20 * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #35;
    chk("R1 reset ready", 64'(key_ready), 64'd0);
    chk("R1 reset valid", 64'(res_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    key_valid = 1'b1; key = lv(3);
    repeat (3) @(negedge clk);
    chk("R1 no accept before load", 64'(key_ready), 64'd0);
    chk("R1 no result before load", 64'(res_valid), 64'd0);
    key_valid = 1'b0;
    load_all();
    lookup(lv(0),  "R3 bin0 head", 0);
    lookup(lv(13), "R4 bin1 last slot", 0);
    lookup(lv(14), "R3 bin2 head", 0);
    lookup(lv(22), "R4 mid", 0);
    lookup(lv(20) + 64'd1, "R5 absent", 0);
    lookup(64'd3,  "R6 below head0", 0);
    lookup(lv(39), "R11 last element", 0);
    lookup(lv(39) + 64'd7, "R11 above all", 0);
    lookup(ONES,   "R10 all-ones", 0);
    lookup(lv(5),  "R9 hold", 3);
    // back-to-back stream, checked by the model every cycle (R8)
    @(negedge clk); res_ready = 1'b1; key_valid = 1'b1; key = lv(30);
    repeat (12) @(negedge clk);
    key_valid = 1'b0;
    repeat (4) @(negedge clk);
    res_ready = 1'b0;
    // reload one word (R2)
    load_we = 1'b1; load_bank = 3'd2; load_addr = 4'd3; load_data = lv(23);
    #1 chk("R2 ready low during write", 64'(key_ready), 64'd0);
    @(negedge clk); load_we = 1'b0;
    chk("R2 ready low until done", 64'(key_ready), 64'd0);
    load_done = 1'b1;
    @(negedge clk); load_done = 1'b0;
    chk("R2 ready after reload", 64'(key_ready), 64'd1);
    lookup(lv(23), "R4 after reload", 1);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule